// File: doc/BRIEF.md
# Qualified Pulse Input with Integrity Counters

This block takes the raw output of a Schmitt-trigger pulse input, as used on a turbine flow sensor, and delivers a clean signal to the rate counter that follows it. The input first passes a two-stage synchronizer. A programmable minimum-width filter then decides which level changes are genuine. Each accepted rising transition produces exactly one single-cycle strobe. A rising transition that follows the previous strobe too closely is treated as an interference pulse and is suppressed.

The block also keeps evidence about the quality of the line. Four saturating counters record accepted pulses, discarded edges, short pulses and suppressed over-rate pulses. A stuck-line detector reports when no transition has been accepted for a programmable number of clocks, and it reports the level the line is stuck at. The strobe is a plain event and carries no handshake: the consumer must accept it in the cycle it appears. The status outputs are plain levels.

Top module: `pulse_qualifier`

## Requirements
- R1: A change of the synchronized input reaches `level_o` only after the synchronized input has held the new value for W consecutive clocks, where W is `min_width_i` and a value of 0 behaves as 1. A level change on `pin_i` appears on `level_o` W+2 clocks later.
- R2: A pulse of the synchronized input that lasts fewer than W clocks increments `minw_cnt_o` by 1. It leaves `level_o` unchanged and produces no strobe.
- R3: For each such short pulse, `reject_cnt_o` increases by 2, one for each of its two discarded edges.
- R4: Each accepted rising transition that is not suppressed raises `pulse_o` for exactly one clock, in the same cycle that `level_o` rises, and increments `accept_cnt_o` by 1.
- R5: An accepted rising transition that occurs fewer than `min_period_i` clocks after the rising transition of the last emitted strobe produces no strobe. It increments `false_cnt_o` instead. Values of 0 and 1 never suppress.
- R6: `stuck_o` is high while at least `stuck_limit_i` clocks have passed since the last accepted transition, or since reset. A limit of 0 disables the detector. `stuck_high_o` is 1 when the line is stuck at 1 and 0 when it is stuck at 0.
- R7: The stuck indication drops in the same cycle that the next accepted transition appears on `level_o`.
- R8: Every counter stops at its full scale of 2^CNT_W-1 and does not wrap.
- R9: A single-cycle `clear_i` zeroes all four counters on the next clock. The clear takes precedence over any increment in that cycle.
- R10: After reset, `level_o`, `pulse_o`, `stuck_o` and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw pulse input, asynchronous to clk |
| min_width_i | input | FILT_W | Minimum stable clocks needed to accept a level change |
| min_period_i | input | PER_W | Minimum clocks between emitted strobes |
| stuck_limit_i | input | STUCK_W | Clocks without an accepted transition before the stuck flag is raised; 0 disables |
| clear_i | input | 1 | Zeroes all counters |
| level_o | output | 1 | Filtered line level |
| pulse_o | output | 1 | One-clock strobe per accepted pulse |
| accept_cnt_o | output | CNT_W | Emitted strobes |
| reject_cnt_o | output | CNT_W | Discarded edges |
| minw_cnt_o | output | CNT_W | Pulses shorter than the minimum width |
| false_cnt_o | output | CNT_W | Over-rate pulses that were suppressed |
| stuck_o | output | 1 | Line has shown no accepted transition for the limit |
| stuck_high_o | output | 1 | Stuck level is high |

## Verification
The bench builds the block with CNT_W=4, FILT_W=3, PER_W=6 and STUCK_W=8. With a 4-bit counter, saturation is reached after a handful of glitches. With a 6-bit spacing counter, the gap saturates within one short idle stretch, so every spacing sweep starts from a known state. The bench sweeps every width setting from 1 to 4 against pulse lengths from 1 to 6, covering the accept/reject boundary on both sides. It also sweeps the pulse spacing from 2 to 12 across a minimum period of 8. The stuck timing is checked one cycle before and one cycle at the limit.

// File: rtl/pq_pkg.sv
package pq_pkg;
  // events produced by the width filter in the current cycle
  typedef struct packed {
    logic rise;
    logic fall;
    logic abort;
  } pq_evt_t;

  localparam int NUM_CNT = 4;
  localparam int IDX_ACC = 0;
  localparam int IDX_REJ = 1;
  localparam int IDX_MINW = 2;
  localparam int IDX_FALSE = 3;
endpackage

// File: rtl/pq_sync.sv
module pq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pq_filter.sv
module pq_filter
  import pq_pkg::*;
#(
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [FILT_W-1:0] min_width,
  output logic              level,
  output pq_evt_t           evt
);
  logic [FILT_W-1:0] run;
  logic [FILT_W-1:0] last;
  logic              differ, fire;

  // a width of zero behaves as one
  assign last   = (min_width == '0) ? '0 : min_width - 1'b1;
  assign differ = (din != level);
  assign fire   = differ && (run == last);

  always_comb begin
    evt.rise  = fire && !level;
    evt.fall  = fire && level;
    evt.abort = !differ && (run != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      run   <= '0;
    end else if (fire) begin
      level <= din;
      run   <= '0;
    end else if (differ) begin
      run <= run + 1'b1;
    end else begin
      run <= '0;
    end
  end
endmodule

// File: rtl/pq_watch.sv
module pq_watch #(
  parameter int PER_W   = 16,
  parameter int STUCK_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               emit,
  input  logic               any_edge,
  input  logic [PER_W-1:0]   min_period,
  input  logic [STUCK_W-1:0] stuck_limit,
  output logic               too_soon,
  output logic               stuck
);
  localparam logic [PER_W-1:0]   GAP_MAX  = '1;
  localparam logic [STUCK_W-1:0] IDLE_MAX = '1;

  logic [PER_W-1:0]   gap;
  logic [STUCK_W-1:0] idle;

  // spacing of a rise now equals gap+1 clocks from the last strobe
  assign too_soon = ({1'b0, gap} + 1'b1) < {1'b0, min_period};
  assign stuck    = (stuck_limit != '0) && (idle >= stuck_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= GAP_MAX;
      idle <= '0;
    end else begin
      if (emit)                gap <= '0;
      else if (gap != GAP_MAX) gap <= gap + 1'b1;

      if (any_edge)              idle <= '0;
      else if (idle != IDLE_MAX) idle <= idle + 1'b1;
    end
  end
endmodule

// File: rtl/pq_sat_cnt.sv
module pq_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [1:0]   step,
  output logic [W-1:0] cnt
);
  logic [W:0] sum;

  assign sum = {1'b0, cnt} + {{(W-1){1'b0}}, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (sum[W]) cnt <= '1;
    else             cnt <= sum[W-1:0];
  end
endmodule

// File: rtl/pulse_qualifier.sv
module pulse_qualifier
  import pq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int FILT_W  = 8,
  parameter int PER_W   = 16,
  parameter int STUCK_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_i,
  input  logic [FILT_W-1:0]  min_width_i,
  input  logic [PER_W-1:0]   min_period_i,
  input  logic [STUCK_W-1:0] stuck_limit_i,
  input  logic               clear_i,
  output logic               level_o,
  output logic               pulse_o,
  output logic [CNT_W-1:0]   accept_cnt_o,
  output logic [CNT_W-1:0]   reject_cnt_o,
  output logic [CNT_W-1:0]   minw_cnt_o,
  output logic [CNT_W-1:0]   false_cnt_o,
  output logic               stuck_o,
  output logic               stuck_high_o
);
  logic       sync_q;
  pq_evt_t    evt;
  logic       too_soon, emit, stuck;
  logic [1:0] step [NUM_CNT];
  logic [CNT_W-1:0] cnt [NUM_CNT];
  logic       pulse_q;

  pq_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(sync_q)
  );

  pq_filter #(.FILT_W(FILT_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .din(sync_q), .min_width(min_width_i),
    .level(level_o), .evt(evt)
  );

  assign emit = evt.rise && !too_soon;

  pq_watch #(.PER_W(PER_W), .STUCK_W(STUCK_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .emit(emit), .any_edge(evt.rise | evt.fall),
    .min_period(min_period_i), .stuck_limit(stuck_limit_i),
    .too_soon(too_soon), .stuck(stuck)
  );

  always_comb begin
    step[IDX_ACC]   = {1'b0, emit};
    step[IDX_REJ]   = evt.abort ? 2'd2 : 2'd0;
    step[IDX_MINW]  = {1'b0, evt.abort};
    step[IDX_FALSE] = {1'b0, evt.rise && too_soon};
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pq_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clear_i), .step(step[i]), .cnt(cnt[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= emit;
  end

  assign pulse_o      = pulse_q;
  assign accept_cnt_o = cnt[IDX_ACC];
  assign reject_cnt_o = cnt[IDX_REJ];
  assign minw_cnt_o   = cnt[IDX_MINW];
  assign false_cnt_o  = cnt[IDX_FALSE];
  assign stuck_o      = stuck;
  assign stuck_high_o = stuck && level_o;
endmodule

// File: rtl/pulse_qualifier_chk.sv
module pulse_qualifier_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             level_o,
  input logic             pulse_o,
  input logic [CNT_W-1:0] accept_cnt_o,
  input logic [CNT_W-1:0] reject_cnt_o,
  input logic [CNT_W-1:0] minw_cnt_o,
  input logic [CNT_W-1:0] false_cnt_o,
  input logic             stuck_o,
  input logic             stuck_high_o
);
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
  a_r4_with_level: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> level_o);
  a_r4_count_tracks_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (pulse_o || accept_cnt_o == $past(accept_cnt_o)));
  a_r8_acc_mono: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> accept_cnt_o >= $past(accept_cnt_o));
  a_r8_rej_mono: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> reject_cnt_o >= $past(reject_cnt_o));
  a_r8_minw_mono: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> minw_cnt_o >= $past(minw_cnt_o));
  a_r8_false_mono: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> false_cnt_o >= $past(false_cnt_o));
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (accept_cnt_o == '0 && reject_cnt_o == '0 &&
                 minw_cnt_o == '0 && false_cnt_o == '0));
  a_r6_high_needs_stuck: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_high_o |-> stuck_o);
  a_r7_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_o) |-> !stuck_o);
endmodule

bind pulse_qualifier pulse_qualifier_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pulse_qualifier_bench.sv
module pulse_qualifier_bench;
  localparam int CNT_W = 4, FILT_W = 3, PER_W = 6, STUCK_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, pin = 1'b0, clr = 1'b0;
  logic [FILT_W-1:0]  minw = 3'd3;
  logic [PER_W-1:0]   minp = '0;
  logic [STUCK_W-1:0] lim  = '0;
  logic level, pulse, stuck, stuck_hi;
  logic [CNT_W-1:0] acc, rej, mw, fls;

  int tests = 0, fails = 0, seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_qualifier #(.CNT_W(CNT_W), .FILT_W(FILT_W), .PER_W(PER_W), .STUCK_W(STUCK_W))
  u_pulse_qualifier (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .min_width_i(minw), .min_period_i(minp),
    .stuck_limit_i(lim), .clear_i(clr), .level_o(level), .pulse_o(pulse),
    .accept_cnt_o(acc), .reject_cnt_o(rej), .minw_cnt_o(mw), .false_cnt_o(fls),
    .stuck_o(stuck), .stuck_high_o(stuck_hi)
  );

  always @(negedge clk) if (rst_n && pulse) seen++;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
  endtask

  function automatic int sat(input int v);
    return (v > 15) ? 15 : v;
  endfunction

  initial begin
    cyc(3);
    check("R10 level", level, 0); check("R10 pulse", pulse, 0);
    check("R10 stuck", stuck, 0);
    check("R10 counters", acc + rej + mw + fls, 0);
    rst_n = 1'b1; cyc(2);

    // R1 latency with W=3: level rises W+2 clocks after the pin
    pin = 1'b1; cyc(4);
    check("R1 level before W+2", level, 0);
    cyc(1);
    check("R1 level at W+2", level, 1);
    check("R4 strobe with level", pulse, 1);
    cyc(1);
    check("R4 strobe one cycle", pulse, 0);
    check("R4 accept count", acc, 1);
    pin = 1'b0; cyc(20);

    // R1/R2/R3/R4 sweep of width against pulse length
    for (int w = 1; w <= 4; w++) begin
      for (int g = 1; g <= 6; g++) begin
        int s0;
        minw = w[FILT_W-1:0]; do_clear(); s0 = seen;
        pin = 1'b1; cyc(g); pin = 1'b0; cyc(20);
        if (g >= w) begin
          check("R1 R4 accepted count", acc, 1);
          check("R4 strobes seen", seen - s0, 1);
          check("R2 no violation", mw, 0);
        end else begin
          check("R2 short pulse count", mw, 1);
          check("R3 two discarded edges", rej, 2);
          check("R2 no strobe", seen - s0, 0);
          check("R2 accept unchanged", acc, 0);
        end
        check("R1 level returns low", level, 0);
      end
    end

    // R5 spacing sweep across min period 8
    minw = 3'd1; minp = 6'd8;
    for (int p = 2; p <= 12; p++) begin
      do_clear(); cyc(80);
      pin = 1'b1; cyc(1); pin = 1'b0; cyc(p - 1);
      pin = 1'b1; cyc(1); pin = 1'b0; cyc(30);
      check("R5 accepted", acc, (p >= 8) ? 2 : 1);
      check("R5 false pulses", fls, (p < 8) ? 1 : 0);
    end
    minp = '0;

    // R8 saturation with short glitches
    minw = 3'd2; do_clear();
    for (int i = 0; i < 10; i++) begin pin = 1'b1; cyc(1); pin = 1'b0; cyc(10); end
    check("R8 minw below scale", mw, 10);
    check("R8 reject saturated", rej, sat(20));
    for (int i = 0; i < 8; i++) begin pin = 1'b1; cyc(1); pin = 1'b0; cyc(10); end
    check("R8 minw saturated", mw, sat(18));
    check("R8 level untouched", level, 0);

    // R9 clear
    do_clear();
    check("R9 cleared", acc + rej + mw + fls, 0);

    // R6/R7 stuck detection, W=1, limit 20
    minw = 3'd1; lim = 8'd20; cyc(30);
    check("R6 stuck low", stuck, 1);
    check("R6 stuck level low", stuck_hi, 0);
    pin = 1'b1; cyc(2);
    check("R7 still stuck before edge", stuck, 1);
    cyc(1);
    check("R7 cleared on edge", stuck, 0);
    cyc(19);
    check("R6 not yet stuck", stuck, 0);
    cyc(1);
    check("R6 stuck at limit", stuck, 1);
    check("R6 stuck high", stuck_hi, 1);
    lim = '0; cyc(1);
    check("R6 limit zero disables", stuck, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule